// File: doc/BRIEF.md
# Integer to Hexadecimal Float Converter

This block turns a 32-bit two's-complement integer into a 32-bit excess-64 floating-point word whose exponent counts powers of sixteen. The packed word has a sign in bit 31, a 7-bit biased exponent in bits 30:24 and a 24-bit fraction in bits 23:0. A negative result is the two's complement of the whole packed positive word. The fraction is normalized so that its leading hexadecimal digit is nonzero. Input bits that do not fit in the 24-bit fraction are truncated, not rounded.

The block also produces a 4-bit condition code that classifies the result as zero, negative or positive. It has an exception flag that this conversion never raises. Operands enter on a valid/ready stream, and each result leaves, with its condition code, on a second valid/ready stream through one register stage. A result that is not taken is held. While the output register is full and the consumer is not ready, `in_ready` is low, so back-pressure reaches the producer in the same cycle. When the consumer takes a result, a new operand can enter in that same cycle, so full throughput is one operand per clock.

Top module: `int2hexflt_conv`

## Requirements
- R1: An input of 0 yields the result word 0x00000000, with condition code 4'b0001 (zero flag only).
- R2: For a positive input x, let k be the number of leading hexadecimal zero digits of x. The result has bit 31 clear, an exponent field (bits 30:24) of 72 - k, and a fraction (bits 23:0) equal to the top 24 bits of x shifted left by 4k. Lower bits are truncated. Examples: 1 gives 0x41100000, and 0x7FFFFFFF gives 0x487FFFFF.
- R3: Every nonzero positive result has a nonzero leading fraction digit (bits 23:20).
- R4: For a negative input, the result is the 32-bit two's complement of the R2 result for the magnitude. Examples: -1 gives 0xBEF00000, and 0x80000000 gives 0xB7800000.
- R5: Condition code bit 2 marks a positive nonzero result, bit 1 a result with bit 31 set, and bit 0 a zero result. Exactly one of these three bits is set.
- R6: Condition code bit 3, the arithmetic-exception flag, is always 0.
- R7: An operand accepted at a rising edge (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_data`/`out_cc` after that same edge. A cycle in which the register is emptied and no operand is accepted leaves `out_valid` low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_cc` hold their values.
- R9: `in_ready` is high exactly when the output register is empty or `out_ready` is high. Results leave in operand order, with none lost and none repeated.
- R10: During reset, `out_valid` is low and `in_ready` is high.
- R11: For a nonzero input, result bit 31 equals input bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | 32 | Two's-complement integer operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Packed hexadecimal float result |
| out_cc | output | 4 | {exception, positive, negative, zero} |

## Verification
Each result is due on the output one clock edge after its operand is accepted. It stays there until a cycle in which `out_ready` is high. The bench keeps a behavioural reference: a queue that holds at most one expected result, filled and drained by the handshakes it predicts. Every clock, at a point between edges after the stimulus has settled, it compares `out_valid`, `in_ready` and, when a result is present, `out_data` and `out_cc` against the head of that queue. This means stalled cycles are checked as well as transfer cycles.

// File: rtl/hexflt_pkg.sv
package hexflt_pkg;

  // Condition code carried beside each result word.
  typedef struct packed {
    logic exc;   // arithmetic exception, never raised by this conversion
    logic gt;    // result greater than zero
    logic lt;    // result negative
    logic eq;    // result zero
  } cond_t;

  localparam int unsigned COND_W = $bits(cond_t);
  localparam int unsigned DIGIT_W = 4;

endpackage

// File: rtl/hexflt_lzc.sv
// Bit-level leading-zero count built from per-digit counters.
module hexflt_lzc #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     val,
  output logic [CNT_W-1:0] count,
  output logic             all_zero
);
  localparam int unsigned GROUPS = W / hexflt_pkg::DIGIT_W;

  logic [GROUPS-1:0] grp_nz;
  logic [1:0]        grp_lz [GROUPS];

  // group 0 is the most significant digit
  for (genvar g = 0; g < GROUPS; g++) begin : g_digit
    logic [3:0] nib;
    assign nib       = val[W-1-4*g -: 4];
    assign grp_nz[g] = |nib;
    always_comb begin
      if (nib[3])      grp_lz[g] = 2'd0;
      else if (nib[2]) grp_lz[g] = 2'd1;
      else if (nib[1]) grp_lz[g] = 2'd2;
      else             grp_lz[g] = 2'd3;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    count = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (!found && grp_nz[g]) begin
        found = 1'b1;
        count = CNT_W'(4 * g) + CNT_W'(grp_lz[g]);
      end
    end
  end

  assign all_zero = ~|grp_nz;

endmodule

// File: rtl/hexflt_pack.sv
// Combinational integer to excess-64 hexadecimal float conversion.
module hexflt_pack
  import hexflt_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned EXP_W = 7,
  parameter int unsigned BIAS  = 64
) (
  input  logic [W-1:0] int_in,
  output logic [W-1:0] flt_out,
  output cond_t        cc
);
  localparam int unsigned CNT_W   = $clog2(W);
  localparam int unsigned FRAC_W  = W - 1 - EXP_W;
  localparam int unsigned EXP_TOP = BIAS + W / DIGIT_W;

  logic             neg;
  logic [W-1:0]     mag;
  logic [CNT_W-1:0] lz;
  logic             mag_zero;
  logic [W-1:0]     norm;
  logic [W-1:0]     aligned;
  logic [EXP_W-1:0] expo;
  logic [W-1:0]     packed_pos;

  assign neg = int_in[W-1];
  assign mag = neg ? (~int_in + 1'b1) : int_in;

  hexflt_lzc #(.W(W), .CNT_W(CNT_W)) u_lzc (
    .val      (mag),
    .count    (lz),
    .all_zero (mag_zero)
  );

  // bit-exact left justification, then back off to a digit boundary
  assign norm    = mag << lz;
  assign aligned = norm >> lz[1:0];
  assign expo    = EXP_W'(EXP_TOP) - EXP_W'(lz >> 2);

  assign packed_pos = {1'b0, expo, aligned[W-1 -: FRAC_W]};

  always_comb begin
    if (mag_zero)  flt_out = '0;
    else if (neg)  flt_out = ~packed_pos + 1'b1;
    else           flt_out = packed_pos;
  end

  always_comb begin
    cc.exc = 1'b0;
    cc.eq  = (flt_out == '0);
    cc.lt  = flt_out[W-1];
    cc.gt  = !cc.eq && !cc.lt;
  end

endmodule

// File: rtl/hexflt_stage.sv
// One register slot with valid/ready on both sides.
module hexflt_stage
  import hexflt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  cond_t        in_cc,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output cond_t        out_cc
);
  logic         vld_q;
  logic [W-1:0] data_q;
  cond_t        cc_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      cc_q   <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= in_data;
        cc_q   <= in_cc;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_cc    = cc_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cc));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);

endmodule

// File: rtl/int2hexflt_conv.sv
module int2hexflt_conv
  import hexflt_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned EXP_W = 7,
  parameter int unsigned BIAS  = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [3:0]   out_cc
);
  localparam int unsigned FRAC_W = W - 1 - EXP_W;

  logic [W-1:0] pk_flt;
  cond_t        pk_cc;
  cond_t        st_cc;

  hexflt_pack #(.W(W), .EXP_W(EXP_W), .BIAS(BIAS)) u_pack (
    .int_in  (in_data),
    .flt_out (pk_flt),
    .cc      (pk_cc)
  );

  hexflt_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pk_flt),
    .in_cc     (pk_cc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_cc    (st_cc)
  );

  assign out_cc = st_cc;

  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_data == '0 |-> pk_flt == '0 && pk_cc == cond_t'(4'b0001));

  p_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_data != '0 && !in_data[W-1] |-> pk_flt[FRAC_W-1 -: 4] != 4'h0);

  p_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pk_cc.gt, pk_cc.lt, pk_cc.eq}) == 1);

  p_noexc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_cc[3]);

  p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_data != '0 |-> pk_flt[W-1] == in_data[W-1]);

endmodule

// File: tb/int2hexflt_conv_tb.sv
`timescale 1ns/1ps
module int2hexflt_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_cc;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] exp_q[$];   // expected results, at most one entry
  logic [31:0] src_q[$];   // matching operands
  logic        stalled_prev = 1'b0;

  always #2 clk = ~clk;    // 250 MHz

  int2hexflt_conv dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_cc
  );

  function automatic logic [31:0] ref_conv(input logic [31:0] x);
    logic [31:0] m;
    logic [31:0] r;
    int k;
    if (x == 32'h0) return 32'h0;
    m = x[31] ? (~x + 32'd1) : x;
    k = 0;
    while (m[31:28] == 4'h0) begin
      m = m << 4;
      k++;
    end
    r = {1'b0, 7'(72 - k), m[31:8]};
    return x[31] ? (~r + 32'd1) : r;
  endfunction

  function automatic logic [3:0] ref_cc(input logic [31:0] r);
    if (r == 32'h0) return 4'b0001;
    if (r[31])      return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cycle(input logic v, input logic [31:0] d, input logic r);
    logic model_full;
    logic fire_in;
    logic fire_out;
    string tag;
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #1;
    model_full = (exp_q.size() != 0);
    check(out_valid == model_full, "R7 out_valid", 32'(out_valid), 32'(model_full));
    check(in_ready == (!model_full || r), "R9 in_ready", 32'(in_ready),
          32'(!model_full || r));
    if (out_valid && model_full) begin
      if (stalled_prev)            tag = "R8 held data";
      else if (src_q[0] == 32'h0)  tag = "R1 zero";
      else if (src_q[0][31])       tag = "R4 negative";
      else                         tag = "R2 positive";
      check(out_data == exp_q[0], tag, out_data, exp_q[0]);
      check(out_cc[2:0] == ref_cc(exp_q[0])[2:0], "R5 cc", 32'(out_cc),
            32'(ref_cc(exp_q[0])));
      check(out_cc[3] == 1'b0, "R6 exception", 32'(out_cc), 32'(ref_cc(exp_q[0])));
      if (src_q[0] != 32'h0) begin
        check(out_data[31] == src_q[0][31], "R11 sign", out_data, exp_q[0]);
        if (!src_q[0][31])
          check(out_data[23:20] != 4'h0, "R3 leading digit", out_data, exp_q[0]);
      end
    end
    fire_out = model_full && r;
    fire_in  = v && (!model_full || r);
    stalled_prev = model_full && !r;
    if (fire_out) begin
      void'(exp_q.pop_front());
      void'(src_q.pop_front());
    end
    if (fire_in) begin
      exp_q.push_back(ref_conv(d));
      src_q.push_back(d);
    end
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'($urandom % 256);
      4: return -32'($urandom % 4096);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] corner [12];
    corner = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
               32'h0000_000F, 32'h0000_0010, 32'h0012_3456, 32'h1234_5678,
               32'hFFFF_FFF0, 32'h0100_0000, 32'h0000_0002};

    // R10: reset values
    repeat (4) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'h0);
      check(in_ready == 1'b1, "R10 in_ready in reset", 32'(in_ready), 32'h1);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R4 spot values against hand-worked words
    check(ref_conv(32'h1) == 32'h4110_0000, "R2 model 1", ref_conv(32'h1), 32'h4110_0000);
    check(ref_conv(32'h8000_0000) == 32'hB780_0000, "R4 model min",
          ref_conv(32'h8000_0000), 32'hB780_0000);

    // corner operands, full throughput
    foreach (corner[i]) cycle(1'b1, corner[i], 1'b1);
    cycle(1'b0, 32'h0, 1'b1);

    // R8: stall with a held result, then release
    cycle(1'b1, 32'hFFFF_FFFF, 1'b1);
    repeat (3) cycle(1'b1, 32'h0000_0001, 1'b0);
    cycle(1'b1, 32'h0000_0001, 1'b1);
    cycle(1'b0, 32'h0, 1'b1);

    // random traffic with random back-pressure
    for (int n = 0; n < 4000; n++)
      cycle(($urandom % 4) != 0, pick_operand(), ($urandom % 3) != 0);

    repeat (4) cycle(1'b0, 32'h0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not end in time");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule